// File: doc/BRIEF.md
# Pulse Repetition Rate Limiter

This block guards a group of identical output channels that drive a power stage. Each channel watches an asynchronous trigger line. It brings the line into the clock domain with a two-flop synchroniser. A rising edge that arrives when the channel is free is turned into one output pulse of a fixed, configured width, after an optional programmable delay. An edge that arrives too soon after the last accepted one is dropped. This caps the duty cycle the power stage sees, whatever the trigger source does.

Two operating modes exist. In standard mode, the pulse width and the minimum spacing come from registers, and the width is always clamped to an absolute ceiling of 8 us. In fast mode, the width is forced to 250 ns, and the spacing is forced to either 2 us (12.5 % duty) or, with the relaxed bit, 500 ns (50 % duty). Each channel keeps two saturating counters, one for received edges and one for emitted pulses. Software reads both through a simple single-cycle register port.

Top module: `pulse_rate_limiter`

## Requirements
- R1: After reset all outputs are low, every counter reads 0, the control register (address 0) reads 0, width (address 1) reads 120, period (address 2) reads 1000 and delay (address 3) reads 0; reads are combinational from `addr`.
- R2: A rising edge on a trigger line produces at most one output pulse; a line held high gives no further pulse, and with zero delay the output rises on the third clock edge after the input rises.
- R3: In standard mode (control bit 0 clear) the pulse lasts exactly the width register in cycles, clamped to 800 cycles (8 us at 100 MHz).
- R4: In fast mode (control bit 0 set) every pulse lasts 25 cycles regardless of the input width and of the width register.
- R5: In fast mode the minimum spacing between accepted edges is 200 cycles, or 50 cycles when control bit 1 is also set.
- R6: In standard mode the minimum spacing between accepted edges is the period register in cycles.
- R7: The output rises delay-register cycles later than it would with zero delay, and a channel refuses new edges until max(spacing, delay + width) cycles have elapsed since the last accepted edge.
- R8: An edge that arrives inside that refusal window raises no pulse; it increments the channel's input counter but not its output counter.
- R9: Channel c's input counter reads at address 8+2c and its output counter at 9+2c; both are 32 bits wide and saturate at all ones.
- R10: Writing 1 to control bit 2 zeroes every counter of every channel, taking priority over an increment in the same cycle; the bit is not stored.
- R11: Channels are independent: triggers on one channel never change another channel's output or counters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, 100 MHz nominal |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | NCH | Asynchronous trigger lines, one per channel |
| pulse_out | output | NCH | Shaped pulses to the power drivers |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register address for write and read |
| wr_data | input | RW | Write data |
| rd_data | output | 32 | Read data for `addr` |

## Verification
The bench aims at the spacing boundary: edges a little before and a little after the refusal window, in each mode and with delay, where an off-by-one comparison would accept a pulse too early or drop one too many. It holds a trigger high for hundreds of cycles, where a level-sensitive design would repeat pulses. It sets a width above the 8 us ceiling, where a missing clamp would overdrive the stage. It times a clear write to collide with a counter increment, where the wrong priority would leave a count of 1. Multiple channels run at once with different rates, where shared state would leak counts or pulses between them.

// File: rtl/pulse_rate_limiter.sv
module pulse_rate_limiter #(
  parameter int NCH       = 6,
  parameter int CNTW      = 32,
  parameter int RW        = 32,
  parameter int FAST_W    = 25,
  parameter int FAST_PER  = 200,
  parameter int RELAX_PER = 50,
  parameter int MAX_W     = 800,
  parameter int STD_W     = 120,
  parameter int STD_PER   = 1000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] trig_in,
  output logic [NCH-1:0] pulse_out,
  input  logic           wr_en,
  input  logic [7:0]     addr,
  input  logic [RW-1:0]  wr_data,
  output logic [31:0]    rd_data
);
  localparam int AW = RW + 2;

  logic          fast, relax;
  logic [RW-1:0] wreg, preg, dreg;
  logic [CNTW-1:0] in_cnt  [NCH];
  logic [CNTW-1:0] out_cnt [NCH];

  wire clr_all = wr_en && addr == 8'd0 && wr_data[2];

  wire [AW-1:0] eff_w = fast ? AW'(FAST_W)
                      : (wreg > RW'(MAX_W) ? AW'(MAX_W) : AW'(wreg));
  wire [AW-1:0] eff_p = fast ? (relax ? AW'(RELAX_PER) : AW'(FAST_PER)) : AW'(preg);
  wire [AW-1:0] hold  = AW'(dreg) + eff_w;
  wire [AW-1:0] lim   = eff_p > hold ? eff_p : hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fast  <= 1'b0;
      relax <= 1'b0;
      wreg  <= RW'(STD_W);
      preg  <= RW'(STD_PER);
      dreg  <= '0;
    end else if (wr_en) begin
      case (addr)
        8'd0: begin fast <= wr_data[0]; relax <= wr_data[1]; end
        8'd1: wreg <= wr_data;
        8'd2: preg <= wr_data;
        8'd3: dreg <= wr_data;
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [2:0]    sy;
    logic [AW-1:0] age;
    wire rise = sy[1] & ~sy[2];
    wire acc  = rise && age >= lim;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sy  <= '0;
        age <= '1;
      end else begin
        sy <= {sy[1:0], trig_in[i]};
        if (acc)          age <= '0;
        else if (~&age)   age <= age + 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n || clr_all) begin
        in_cnt[i]  <= '0;
        out_cnt[i] <= '0;
      end else begin
        if (rise && ~&in_cnt[i])  in_cnt[i]  <= in_cnt[i] + 1'b1;
        if (acc  && ~&out_cnt[i]) out_cnt[i] <= out_cnt[i] + 1'b1;
      end
    end

    assign pulse_out[i] = age >= AW'(dreg) && age < hold;
  end

  always_comb begin
    rd_data = '0;
    case (addr)
      8'd0: rd_data = {30'd0, relax, fast};
      8'd1: rd_data = 32'(wreg);
      8'd2: rd_data = 32'(preg);
      8'd3: rd_data = 32'(dreg);
      default: ;
    endcase
    for (int c = 0; c < NCH; c++) begin
      if (addr == 8'(8 + 2*c)) rd_data = 32'(in_cnt[c]);
      if (addr == 8'(9 + 2*c)) rd_data = 32'(out_cnt[c]);
    end
  end
endmodule

// File: rtl/pulse_rate_limiter_chk.sv
module pulse_rate_limiter_chk #(
  parameter int NCH   = 6,
  parameter int CNTW  = 32,
  parameter int MAX_W = 800
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NCH-1:0]  pulse_out,
  input logic            clr_all,
  input logic [CNTW-1:0] in_cnt  [NCH],
  input logic [CNTW-1:0] out_cnt [NCH]
);
  localparam int RUNW = $clog2(MAX_W + 2) + 1;

  for (genvar i = 0; i < NCH; i++) begin : g_c
    logic [RUNW-1:0] run;
    always_ff @(posedge clk) begin
      if (!rst_n || !pulse_out[i]) run <= '0;
      else if (~&run)              run <= run + 1'b1;
    end

    AST_WIDTH_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
      run <= RUNW'(MAX_W));  // R3
    AST_OUT_NOT_ABOVE_IN: assert property (@(posedge clk) disable iff (!rst_n)
      out_cnt[i] <= in_cnt[i]);  // R8
    AST_IN_CNT_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_all |=> in_cnt[i] >= $past(in_cnt[i]));  // R9
    AST_OUT_CNT_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_all |=> out_cnt[i] >= $past(out_cnt[i]));  // R9
    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      clr_all |=> (in_cnt[i] == '0 && out_cnt[i] == '0));  // R10
  end
endmodule

bind pulse_rate_limiter pulse_rate_limiter_chk #(
  .NCH(NCH), .CNTW(CNTW), .MAX_W(MAX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pulse_out(pulse_out),
  .clr_all(clr_all), .in_cnt(in_cnt), .out_cnt(out_cnt)
);

// File: tb/pulse_rate_limiter_bench.sv
module pulse_rate_limiter_bench;
  localparam int NCH = 6;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] trig_in = '0;
  logic [NCH-1:0] pulse_out;
  logic           wr_en = 1'b0;
  logic [7:0]     addr = '0;
  logic [31:0]    wr_data = '0;
  logic [31:0]    rd_data;

  always #5 clk = ~clk;

  pulse_rate_limiter u_pulse_rate_limiter (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .pulse_out(pulse_out),
    .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
  );

  int compared = 0, mismatched = 0;
  bit done = 0;
  string tag = "R1";

  // behavioural reference
  bit          m_fast, m_relax;
  longint      m_w, m_p, m_d, cyc = 0;
  longint      last [NCH];
  bit [2:0]    hist [NCH];
  int unsigned icnt [NCH];
  int unsigned ocnt [NCH];

  function automatic longint width_now();
    if (m_fast) return 25;
    return (m_w > 800) ? 800 : m_w;
  endfunction

  function automatic longint window_now();
    longint p, h;
    p = m_fast ? (m_relax ? 50 : 200) : m_p;
    h = m_d + width_now();
    return (p > h) ? p : h;
  endfunction

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) begin
      m_fast = 0; m_relax = 0; m_w = 120; m_p = 1000; m_d = 0;
      for (int c = 0; c < NCH; c++) begin
        last[c] = -1; hist[c] = 0; icnt[c] = 0; ocnt[c] = 0;
      end
    end else begin
      longint l;
      l = window_now();
      for (int c = 0; c < NCH; c++) begin
        if (hist[c][1] && !hist[c][2]) begin
          icnt[c]++;
          if (last[c] < 0 || (cyc - 1 - last[c]) >= l) begin
            last[c] = cyc;
            ocnt[c]++;
          end
        end
        hist[c] = {hist[c][1:0], trig_in[c]};
      end
      if (wr_en) begin
        case (addr)
          8'd0: begin
            m_fast = wr_data[0]; m_relax = wr_data[1];
            if (wr_data[2])
              for (int c = 0; c < NCH; c++) begin icnt[c] = 0; ocnt[c] = 0; end
          end
          8'd1: m_w = wr_data;
          8'd2: m_p = wr_data;
          8'd3: m_d = wr_data;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int c = 0; c < NCH; c++) begin
        bit exp;
        longint age;
        age = cyc - last[c];
        exp = last[c] >= 0 && age >= m_d && age < m_d + width_now();
        compared++;
        if (pulse_out[c] !== exp) begin
          mismatched++;
          $display("FAIL %s: pulse_out[%0d] at cycle %0d = %b, expected %b",
                   tag, c, cyc, pulse_out[c], exp);
        end
      end
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(input logic [7:0] a, input logic [31:0] exp, input string t);
    @(negedge clk);
    addr = a;
    #1;
    compared++;
    if (rd_data !== exp) begin
      mismatched++;
      $display("FAIL %s: rd_data[addr %0d] = %0d, expected %0d", t, a, rd_data, exp);
    end
  endtask

  task automatic check_counts(input int c, input string t);
    rd_check(8'(8 + 2*c), icnt[c], t);
    rd_check(8'(9 + 2*c), ocnt[c], t);
  endtask

  task automatic pulse(input int c, input int len);
    @(negedge clk);
    trig_in[c] = 1'b1;
    wait_cyc(len);
    trig_in[c] = 1'b0;
  endtask

  initial begin
    wait_cyc(4);
    rst_n = 1'b1;
    // R1 reset state
    rd_check(0, 0, "R1");
    rd_check(1, 120, "R1");
    rd_check(2, 1000, "R1");
    rd_check(3, 0, "R1");
    for (int c = 0; c < NCH; c++) begin
      rd_check(8'(8 + 2*c), 0, "R1");
      rd_check(8'(9 + 2*c), 0, "R1");
    end

    // R2 single edge, one pulse; held input repeats nothing
    tag = "R2";
    pulse(0, 5);
    wait_cyc(200);
    check_counts(0, "R2");
    rd_check(8, 1, "R2");
    rd_check(9, 1, "R2");
    pulse(1, 2500);
    wait_cyc(50);
    rd_check(11, 1, "R2");

    // R6 R8 standard spacing: early edge dropped, late edge accepted
    tag = "R6";
    wait_cyc(1200);
    pulse(0, 3); wait_cyc(997);
    pulse(0, 3); wait_cyc(4);
    pulse(0, 3); wait_cyc(1500);
    tag = "R8";
    check_counts(0, "R8");

    // R3 width register and 8 us clamp
    tag = "R3";
    wr(1, 40);
    pulse(2, 3); wait_cyc(1100);
    wr(1, 2000);
    pulse(2, 3); wait_cyc(1100);
    wr(1, 800);
    pulse(2, 3); wait_cyc(1100);
    check_counts(2, "R3");

    // R4 R5 fast mode: fixed width, 200-cycle spacing
    tag = "R4";
    wr(0, 1);
    for (int k = 0; k < 6; k++) begin pulse(3, 90); wait_cyc(9); end
    tag = "R5";
    for (int k = 0; k < 4; k++) begin pulse(3, 3); wait_cyc(196); end
    wait_cyc(300);
    check_counts(3, "R5");
    wr(0, 3);
    for (int k = 0; k < 5; k++) begin pulse(3, 3); wait_cyc(46); end
    for (int k = 0; k < 5; k++) begin pulse(3, 3); wait_cyc(26); end
    wait_cyc(100);
    check_counts(3, "R5");

    // R7 delay stretches the window to delay + width
    tag = "R7";
    wr(3, 30);
    for (int k = 0; k < 6; k++) begin pulse(4, 3); wait_cyc(49); end
    for (int k = 0; k < 4; k++) begin pulse(4, 3); wait_cyc(53); end
    wait_cyc(100);
    check_counts(4, "R7");
    wr(3, 0);

    // R11 two channels at different rates
    tag = "R11";
    wr(0, 1);
    for (int k = 0; k < 1500; k++) begin
      @(negedge clk);
      trig_in[4] = (k % 150) < 4;
      trig_in[5] = (k % 110) < 4;
    end
    trig_in[4] = 0; trig_in[5] = 0;
    wait_cyc(300);
    for (int c = 0; c < NCH; c++) check_counts(c, "R11");

    // R9 address map recheck, R10 clear colliding with an increment
    tag = "R10";
    @(negedge clk);
    trig_in[0] = 1'b1;
    wait_cyc(1);
    wr(0, 32'h5);
    trig_in[0] = 1'b0;
    wait_cyc(20);
    for (int c = 0; c < NCH; c++) begin
      rd_check(8'(8 + 2*c), 0, "R10");
      rd_check(8'(9 + 2*c), 0, "R10");
    end
    rd_check(0, 1, "R10");
    tag = "R9";
    pulse(5, 3); wait_cyc(60);
    check_counts(5, "R9");
    rd_check(19, 1, "R9");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule